// File: doc/BRIEF.md
# Alert Latch and Clear Controller for a Power-Supply Management Interface

This block drives the active-low alert line that a power supply uses to call its host's attention. It watches a vector of level-type condition bits, such as supply or output voltage out of range, over current, over temperature, fan failure and internal fault. It also watches a vector of single-cycle error pulses, such as bus error, checksum error and unknown command. Any change in those inputs pulls the alert low, and the alert stays low until the host or a power cycle clears it.

Four events clear the alert:
- a clear-faults command strobe;
- a strobe marking a read of the status word;
- the main output being switched off and back on through its enable pin;
- the main output being switched off and back on through the operation command.

On a clear, the sticky status bits are emptied and at once refilled from the conditions that are still active. If any condition is still active, the alert does not release.

The block also holds the sticky status bits that a status read returns. Sensor measurement and command decoding happen elsewhere. This block only receives their results as levels and strobes.

Top module: `smb_alert_ctrl`

## Requirements
- R1: While `rst_n` is low, `alert_n_o` is 1 and `status_o` is all zero.
- R2: When any bit of `cond_i` differs from its value in the previous cycle, rising or falling, `alert_n_o` is 0 after the next clock edge. The previous-cycle copy of `cond_i` is all zero out of reset, so a condition that is already active at reset release also raises the alert.
- R3: A 1 on bit j of `err_pulse_i` drives `alert_n_o` to 0 and sets `status_o[NCOND+j]` after the next clock edge.
- R4: A rising edge on `cond_i[i]` sets `status_o[i]`. In cycles without a clear event, no status bit goes from 1 to 0, even when its condition falls.
- R5: When no clear event occurs, a low `alert_n_o` stays low.
- R6: A 1 on `clr_faults_i` or on `stat_read_i`, with no condition active and no new change or pulse in that cycle, makes `alert_n_o` 1 and `status_o` zero after the next clock edge.
- R7: `out_en_i` counts as a clear event in the cycle it is 1 after having been 0 in the previous cycle. Going low alone does not clear, and staying high does not clear.
- R8: `op_on_i` counts as a clear event under the same rule as R7. It is the output on/off state set by the operation command.
- R9: On a clear event, `status_o[NCOND-1:0]` is reloaded with `cond_i`. If any condition is active, `alert_n_o` stays 0 with no high cycle.
- R10: When a clear event coincides with a condition change or an error pulse, the alert stays 0. The bit of that new edge or pulse is set in `status_o` after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | NCOND | Level-type condition bits, 1 = condition active |
| err_pulse_i | input | NERR | Single-cycle communication error pulses |
| clr_faults_i | input | 1 | Clear-faults command strobe |
| stat_read_i | input | 1 | Status-word read strobe |
| out_en_i | input | 1 | Main output enable pin level, 1 = on |
| op_on_i | input | 1 | Main output on/off state from the operation command, 1 = on |
| alert_n_o | output | 1 | Alert line, active low |
| status_o | output | NCOND+NERR | Sticky status: condition bits low, error bits high |

## Verification
Both outputs come straight from registers. Every result therefore shows up exactly one clock edge after the inputs that cause it are sampled, with no extra latency for the recycle detection. The recycle detector compares the level with a one-flop copy of its previous value. Its clear lands on the same edge that samples the return to high.

The bench drives inputs one time unit after a rising edge and samples one time unit after the next rising edge. Each check therefore sees the outcome of exactly one edge. For the paths that must not clear or release, the bench also checks in the cycles between stimuli.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    // Sources that release the alert; enum value is the bit index in the clear vector.
    typedef enum logic [1:0] {
        CLR_CMD    = 2'd0,
        CLR_READ   = 2'd1,
        CLR_EN_CYC = 2'd2,
        CLR_OP_CYC = 2'd3
    } clr_src_e;

    localparam int unsigned CLR_SRCS = 4;
    localparam int unsigned RECYCLE_SRCS = 2;

endpackage

// File: rtl/smb_cond_track.sv
module smb_cond_track #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    output logic         chg_o,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.prev = cond_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign chg_o  = |(cond_i ^ trk_q.prev);
    assign rise_o = cond_i & ~trk_q.prev;

    // R4: a reported rising bit must be high now.
    assert_rise_is_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & ~cond_i) == '0));

endmodule

// File: rtl/smb_recycle_det.sv
module smb_recycle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);

    typedef struct packed {
        logic was_off;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d         = rec_q;
        rec_d.was_off = ~lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign pulse_o = lvl_i & rec_q.was_off;

    // R7: no two recycle pulses in consecutive cycles.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl
    import smb_alert_pkg::*;
#(
    parameter int unsigned NCOND = 9,
    parameter int unsigned NERR  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCOND-1:0]      cond_i,
    input  logic [NERR-1:0]       err_pulse_i,
    input  logic                  clr_faults_i,
    input  logic                  stat_read_i,
    input  logic                  out_en_i,
    input  logic                  op_on_i,
    output logic                  alert_n_o,
    output logic [NCOND+NERR-1:0] status_o
);

    localparam int unsigned NSTAT = NCOND + NERR;

    typedef struct packed {
        logic             alert;
        logic [NSTAT-1:0] sticky;
    } core_t;

    core_t core_d, core_q;

    logic                    trk_chg;
    logic [NCOND-1:0]        trk_rise;
    logic [RECYCLE_SRCS-1:0] rec_lvl;
    logic [RECYCLE_SRCS-1:0] rec_pulse;
    logic [CLR_SRCS-1:0]     clr_vec;
    logic                    clr_any;
    logic                    new_event;

    smb_cond_track #(.W(NCOND)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_i),
        .chg_o  (trk_chg),
        .rise_o (trk_rise)
    );

    assign rec_lvl = {op_on_i, out_en_i};

    for (genvar g = 0; g < RECYCLE_SRCS; g++) begin : g_recycle
        smb_recycle_det u_rec (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (rec_lvl[g]),
            .pulse_o (rec_pulse[g])
        );
    end

    always_comb begin
        clr_vec             = '0;
        clr_vec[CLR_CMD]    = clr_faults_i;
        clr_vec[CLR_READ]   = stat_read_i;
        clr_vec[CLR_EN_CYC] = rec_pulse[0];
        clr_vec[CLR_OP_CYC] = rec_pulse[1];
    end

    assign clr_any   = |clr_vec;
    assign new_event = trk_chg | (|err_pulse_i);

    always_comb begin
        core_d = core_q;
        if (clr_any) begin
            // Empty, then refill from what is still active; new edges win.
            core_d.sticky = {err_pulse_i, cond_i};
            core_d.alert  = new_event | (|cond_i);
        end else begin
            core_d.sticky = core_q.sticky | {err_pulse_i, trk_rise};
            core_d.alert  = core_q.alert | new_event;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign alert_n_o = ~core_q.alert;
    assign status_o  = core_q.sticky;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (alert_n_o && status_o == '0));

    assert_change_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trk_chg |=> !alert_n_o);

    assert_err_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_pulse_i) |=> (!alert_n_o &&
            ((status_o[NSTAT-1:NCOND] & $past(err_pulse_i)) == $past(err_pulse_i))));

    assert_sticky_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_any |=> ((status_o & $past(status_o)) == $past(status_o)));

    assert_alert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_n_o && !clr_any) |=> !alert_n_o);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && !(|cond_i) && !new_event) |=> (alert_n_o && status_o == '0));

    assert_persist_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|cond_i) |=> !alert_n_o);

    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (status_o[NCOND-1:0] == $past(cond_i)));

endmodule

// File: tb/test_smb_alert_ctrl.sv
module test_smb_alert_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NE = 2;
    localparam int NS = NC + NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] cond = '0;
    logic [NE-1:0] errp = '0;
    logic          clrf = 1'b0;
    logic          srd = 1'b0;
    logic          en = 1'b1;
    logic          opon = 1'b1;
    logic          alert_n;
    logic [NS-1:0] status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    smb_alert_ctrl #(.NCOND(NC), .NERR(NE)) i_smb_alert_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond_i       (cond),
        .err_pulse_i  (errp),
        .clr_faults_i (clrf),
        .stat_read_i  (srd),
        .out_en_i     (en),
        .op_on_i      (opon),
        .alert_n_o    (alert_n),
        .status_o     (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Latch the alert through an error pulse with all conditions idle.
    task automatic latch_by_err();
        cond = '0;
        step();
        clrf = 1'b1;
        step();
        clrf = 1'b0;
        errp = 2'b01;
        step();
        errp = '0;
    endtask

    initial begin
        cond = 4'b0011;
        #3;
        chk("R1 alert in reset", int'(alert_n), 1);
        chk("R1 status in reset", int'(status), 0);
        step();
        rst_n = 1'b1;
        step();
        chk("R2 active at reset release", int'(alert_n), 0);
        chk("R4 active at reset release", int'(status), 3);

        // Sweep every pair of condition patterns a -> b.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                cond = NC'(a);
                step();
                step();
                clrf = 1'b1;
                step();
                clrf = 1'b0;
                chk("R9 reload after clear", int'(status), a);
                chk("R9 alert after clear", int'(alert_n), (a == 0) ? 1 : 0);
                cond = NC'(b);
                step();
                chk("R4 sticky after change", int'(status), a | b);
                chk("R2 alert after change", int'(alert_n),
                    (a == b) ? ((a == 0) ? 1 : 0) : 0);
            end
        end

        // R3: each error pulse bit, cleared by a status read (R6).
        for (int j = 0; j < NE; j++) begin
            cond = '0;
            step();
            srd = 1'b1;
            step();
            srd = 1'b0;
            chk("R6 read releases", int'(alert_n), 1);
            chk("R6 read empties status", int'(status), 0);
            errp = NE'(1 << j);
            step();
            errp = '0;
            chk("R3 pulse alert", int'(alert_n), 0);
            chk("R3 pulse status bit", int'(status), 1 << (NC + j));
            step();
            step();
            chk("R5 alert held", int'(alert_n), 0);
            chk("R4 error bit held", int'(status), 1 << (NC + j));
        end

        // R7: enable recycle.
        latch_by_err();
        step();
        chk("R7 enable steady high no clear", int'(alert_n), 0);
        en = 1'b0;
        step();
        chk("R7 enable low alone no clear", int'(alert_n), 0);
        step();
        chk("R7 enable held low no clear", int'(alert_n), 0);
        en = 1'b1;
        step();
        chk("R7 enable recycle clears", int'(alert_n), 1);
        chk("R7 enable recycle status", int'(status), 0);

        // R8: operation command recycle.
        latch_by_err();
        opon = 1'b0;
        step();
        chk("R8 op off alone no clear", int'(alert_n), 0);
        opon = 1'b1;
        step();
        chk("R8 op recycle clears", int'(alert_n), 1);
        step();
        chk("R8 op steady no change", int'(alert_n), 1);

        // R10: clear coinciding with an error pulse.
        latch_by_err();
        clrf = 1'b1;
        errp = 2'b10;
        step();
        clrf = 1'b0;
        errp = '0;
        chk("R10 clear+pulse alert", int'(alert_n), 0);
        chk("R10 clear+pulse status", int'(status), 1 << (NC + 1));

        // R10: clear coinciding with a condition rising edge.
        latch_by_err();
        srd = 1'b1;
        cond = 4'b1000;
        step();
        srd = 1'b0;
        chk("R10 clear+edge alert", int'(alert_n), 0);
        chk("R10 clear+edge status", int'(status), 8);

        // R9: persisting condition never releases across several clears.
        cond = 4'b0101;
        errp = 2'b11;
        step();
        errp = '0;
        for (int k = 0; k < 3; k++) begin
            clrf = 1'b1;
            step();
            clrf = 1'b0;
            chk("R9 persist alert", int'(alert_n), 0);
            chk("R9 persist status", int'(status), 5);
            step();
            chk("R9 persist between clears", int'(alert_n), 0);
        end

        // R2: falling edge alone raises the alert.
        cond = '0;
        step();
        clrf = 1'b1;
        step();
        clrf = 1'b0;
        chk("R6 clear idle", int'(alert_n), 1);
        cond = 4'b0010;
        step();
        step();
        clrf = 1'b1;
        step();
        clrf = 1'b0;
        cond = '0;
        step();
        chk("R2 falling edge alert", int'(alert_n), 0);
        chk("R4 falling edge no new bit", int'(status), 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule